// File: doc/BRIEF.md
# Programmable Dual-Table Logic Slice

This block is a small programmable logic cell of the kind tiled across a reconfigurable fabric. It holds two 4-input look-up tables. Each table has sixteen storage bits, and its four inputs pick one of those bits as the table's output. Each table is set to one of three uses: a fixed truth table, a 16-deep serial delay line with an addressable tap, or a 16x1 memory with a synchronous write and an asynchronous read. A second-level multiplexer, steered by a fifth input, picks one of the two table outputs, so the pair can implement any 5-input function. Two flip-flops sit behind the cell. Each has a clock enable, a local set/reset pin and a global set/reset pin. A programming bit per output chooses whether that output shows the flip-flop or the combinational path.

All programming bits are loaded through one serial scan chain at one bit per clock while `cfg_en` is high. The stream is sent in this order: the sixteen bits of table A (bit 15 first), the sixteen bits of table B (bit 15 first), and then eight control bits. The control bits, in sending order, are: mode A (2 bits, MSB first), mode B (2 bits, MSB first), the output select for the table-A output, the output select for the 5-input output, the set/reset value for the table-A flop, and the set/reset value for the 5-input flop. The mode codes are 0 for logic, 1 for shift and 2 for RAM; code 3 behaves as logic. The last bit of table A drives `cfg_so`, so several slices can be daisy-chained.

Top module: `cfg_slice`

## Requirements
- R1: After a low `rst_n` at a clock edge, all table bits, control bits and flip-flops are 0, so every output reads 0.
- R2: While `cfg_en` is high, each clock moves the chain one place. `cfg_so` presents the bit that entered at `cfg_si` 40 shifts earlier. After a full load, `cfg_so` equals bit 15 of table A.
- R3: In logic mode, `comb_a` equals bit `a_in` of table A, and table B likewise returns bit `b_in` of its table.
- R4: `comb_f5` equals the table-B output when `sel5` is 1 and the table-A output when `sel5` is 0.
- R5: In shift mode, each clock with the table's write enable high moves its bits up by one and loads the data input into bit 0. The output is the bit at the addressed position, so with address 15 a bit appears after 16 enabled clocks.
- R6: In RAM mode, a clock with write enable high stores the data input at the addressed bit. The output is an asynchronous read of the addressed bit.
- R7: In logic mode, the write enable and data inputs leave the table unchanged.
- R8: With both set/reset pins low and no load in progress, a flop captures its input when `ce` is 1 and holds when `ce` is 0. The table-A flop samples the table-A output; the other flop samples the 5-input result.
- R9: When `sr` or `gsr` is 1, each flop loads its programmed set/reset value on that clock, whatever `ce` is.
- R10: An output-select bit of 1 routes the flop to `out_a` or `out_f5`; a 0 routes the combinational value.
- R11: While `cfg_en` is high, both flops are held at 0, and user writes and shifts do not reach the tables.
- R12: Mode code 3 behaves exactly like logic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 4 | Table A select/address |
| b_in | input | 4 | Table B select/address |
| sel5 | input | 1 | Fifth input; picks table B when 1 |
| din_a | input | 1 | Table A data in (shift/RAM modes) |
| we_a | input | 1 | Table A write/shift enable |
| din_b | input | 1 | Table B data in |
| we_b | input | 1 | Table B write/shift enable |
| ce | input | 1 | Flop clock enable |
| sr | input | 1 | Local set/reset |
| gsr | input | 1 | Global set/reset |
| cfg_en | input | 1 | Scan-chain load enable |
| cfg_si | input | 1 | Scan-chain serial in |
| cfg_so | output | 1 | Scan-chain serial out |
| comb_a | output | 1 | Table A combinational output |
| comb_f5 | output | 1 | 5-input combinational output |
| out_a | output | 1 | Table A output after output select |
| out_f5 | output | 1 | 5-input output after output select |

## Verification
The two functions that can fall in the same clock are a RAM write into table A and a capture of that table's output by its flip-flop. The bench provokes this by setting RAM mode with the flop routed to `out_a`, then raising `we_a` and `ce` together at an address that holds 0 while the data input is 1. After the edge, `comb_a` must show the new 1 while `out_a` must still hold the old 0, which the flop took before the write landed. A second conflict, `sr` raised with `ce` high, is judged by requiring the programmed set/reset value rather than the table output.

// File: rtl/slice_pkg.sv
// Shared definitions for the programmable logic slice: table size,
// mode encoding and the layout of the control part of the scan chain.
package slice_pkg;
    localparam int LUT_K   = 4;
    localparam int LUT_D   = 1 << LUT_K;
    localparam int N_LUT   = 2;

    typedef enum logic [1:0] {
        LM_LOGIC     = 2'd0,
        LM_SHIFT     = 2'd1,
        LM_RAM       = 2'd2,
        LM_LOGIC_ALT = 2'd3
    } lut_mode_e;

    // Control bits; field order fixes the position in the chain (MSB sent first).
    typedef struct packed {
        lut_mode_e mode_a;
        lut_mode_e mode_b;
        logic      osel_a;
        logic      osel_f;
        logic      srv_a;
        logic      srv_f;
    } slice_ctl_t;

    localparam int CTL_W   = $bits(slice_ctl_t);
    localparam int CHAIN_W = N_LUT * LUT_D + CTL_W;
endpackage

// File: rtl/slice_lut.sv
// One look-up table with three uses of its storage bits.
// Assumes: cfg_en has priority over all user activity; in shift and RAM
// modes 'we' qualifies the clock. Scan order runs bits[0] -> bits[D-1].
module slice_lut
    import slice_pkg::*;
#(
    parameter int K = LUT_K,
    localparam int D = 1 << K
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_in,
    output logic         cfg_out,
    input  lut_mode_e    mode,
    input  logic [K-1:0] addr,
    input  logic         din,
    input  logic         we,
    output logic         dout,
    output logic [D-1:0] bits_o
);
    logic [D-1:0] bits;

    // Storage update: scan load, serial shift, or single-bit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (cfg_en) begin
            bits <= {bits[D-2:0], cfg_in};
        end else if (we) begin
            case (mode)
                LM_SHIFT: bits <= {bits[D-2:0], din};
                LM_RAM:   bits[addr] <= din;
                default:  bits <= bits;
            endcase
        end
    end

    // Read path: the inputs select one stored bit in every mode.
    always_comb begin
        dout = bits[addr];
    end

    assign cfg_out = bits[D-1];
    assign bits_o  = bits;
endmodule

// File: rtl/slice_ctrl.sv
// Control segment of the scan chain: modes, output selects and set/reset
// values. Assumes it sits at the serial-input end of the chain.
module slice_ctrl
    import slice_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic       cfg_in,
    output logic       cfg_out,
    output slice_ctl_t ctl
);
    logic [CTL_W-1:0] sreg;

    // Shift the control bits while a load is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (cfg_en) begin
            sreg <= {sreg[CTL_W-2:0], cfg_in};
        end
    end

    assign ctl     = slice_ctl_t'(sreg);
    assign cfg_out = sreg[CTL_W-1];
endmodule

// File: rtl/slice_ff.sv
// Output flip-flop with clock enable and set/reset to a programmed value.
// Assumes hold (scan load) forces 0 and outranks set/reset and enable.
module slice_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ce,
    input  logic srst,
    input  logic srval,
    input  logic d,
    output logic q
);
    // Priority: reset/hold, then set/reset, then enabled capture.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            q <= 1'b0;
        end else if (srst) begin
            q <= srval;
        end else if (ce) begin
            q <= d;
        end
    end
endmodule

// File: rtl/cfg_slice.sv
// Programmable slice: two tables, a fifth-input combiner, two flops and a
// serial scan chain (serial in -> control -> table B -> table A -> serial out).
// Assumes one clock domain; all configuration is loaded while cfg_en is high.
module cfg_slice
    import slice_pkg::*;
#(
    parameter int K = LUT_K,
    localparam int D = 1 << K
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] a_in,
    input  logic [K-1:0] b_in,
    input  logic         sel5,
    input  logic         din_a,
    input  logic         we_a,
    input  logic         din_b,
    input  logic         we_b,
    input  logic         ce,
    input  logic         sr,
    input  logic         gsr,
    input  logic         cfg_en,
    input  logic         cfg_si,
    output logic         cfg_so,
    output logic         comb_a,
    output logic         comb_f5,
    output logic         out_a,
    output logic         out_f5
);
    slice_ctl_t                  ctl;
    logic                        ctl_so;
    logic [N_LUT-1:0]            lut_cin;
    logic [N_LUT-1:0]            lut_cout;
    logic [N_LUT-1:0]            lut_o;
    logic [N_LUT-1:0]            lut_we;
    logic [N_LUT-1:0]            lut_din;
    logic [N_LUT-1:0][K-1:0]     lut_addr;
    lut_mode_e                   lut_mode [N_LUT];
    logic [N_LUT-1:0][D-1:0]     lut_bits;
    logic                        f5;
    logic [1:0]                  ff_d;
    logic [1:0]                  ff_sv;
    logic [1:0]                  ff_q;
    logic                        srst;

    slice_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_in  (cfg_si),
        .cfg_out (ctl_so),
        .ctl     (ctl)
    );

    // Per-table wiring; index 0 is table A, index 1 is table B.
    assign lut_addr = {b_in, a_in};
    assign lut_we   = {we_b, we_a};
    assign lut_din  = {din_b, din_a};
    assign lut_cin  = {ctl_so, lut_cout[1]};
    assign lut_mode[0] = ctl.mode_a;
    assign lut_mode[1] = ctl.mode_b;

    for (genvar i = 0; i < N_LUT; i++) begin : g_lut
        slice_lut #(.K(K)) u_lut (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_en  (cfg_en),
            .cfg_in  (lut_cin[i]),
            .cfg_out (lut_cout[i]),
            .mode    (lut_mode[i]),
            .addr    (lut_addr[i]),
            .din     (lut_din[i]),
            .we      (lut_we[i]),
            .dout    (lut_o[i]),
            .bits_o  (lut_bits[i])
        );
    end

    // Fifth-input combiner.
    always_comb begin
        f5 = sel5 ? lut_o[1] : lut_o[0];
    end

    assign srst  = sr | gsr;
    assign ff_d  = {f5, lut_o[0]};
    assign ff_sv = {ctl.srv_f, ctl.srv_a};

    for (genvar j = 0; j < 2; j++) begin : g_ff
        slice_ff u_ff (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (cfg_en),
            .ce    (ce),
            .srst  (srst),
            .srval (ff_sv[j]),
            .d     (ff_d[j]),
            .q     (ff_q[j])
        );
    end

    // Output selection between combinational and registered paths.
    always_comb begin
        comb_a  = lut_o[0];
        comb_f5 = f5;
        out_a   = ctl.osel_a ? ff_q[0] : lut_o[0];
        out_f5  = ctl.osel_f ? ff_q[1] : f5;
    end

    assign cfg_so = lut_cout[0];
endmodule

// File: rtl/slice_chk.sv
// Checker for cfg_slice, bound to every instance. Observes flop state,
// table A storage and control fields through the top's internal nets.
module slice_chk
    import slice_pkg::*;
#(
    parameter int K = LUT_K,
    localparam int D = 1 << K
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_en,
    input logic         ce,
    input logic         sr,
    input logic         gsr,
    input logic         we_a,
    input logic         din_a,
    input logic [K-1:0] a_in,
    input logic         comb_a,
    input logic [1:0]   ff_q,
    input logic [1:0]   ff_sv,
    input lut_mode_e    mode_a,
    input logic [D-1:0] bits_a
);
    // R11: a load in progress clears both flops.
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (ff_q == 2'b00));

    // R8: no enable, no set/reset, no load: flops keep their value.
    assert_ce_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !ce && !sr && !gsr) |=> $stable(ff_q));

    // R9: set/reset loads the programmed values.
    assert_sr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && (sr || gsr)) |=> (ff_q == $past(ff_sv)));

    // R7: logic-mode storage is not touched by user activity.
    assert_logic_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && (mode_a == LM_LOGIC || mode_a == LM_LOGIC_ALT)) |=> $stable(bits_a));

    // R6: a RAM write is read back at the same address on the next cycle.
    assert_ram_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && mode_a == LM_RAM && we_a) |=> (!$stable(a_in) || comb_a == $past(din_a)));
endmodule

bind cfg_slice slice_chk #(.K(K)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .ce     (ce),
    .sr     (sr),
    .gsr    (gsr),
    .we_a   (we_a),
    .din_a  (din_a),
    .a_in   (a_in),
    .comb_a (comb_a),
    .ff_q   (ff_q),
    .ff_sv  (ff_sv),
    .mode_a (ctl.mode_a),
    .bits_a (lut_bits[0])
);

// File: tb/sim_cfg_slice.sv
// Self-checking bench for cfg_slice: a vector table of logic-mode cases,
// then random and directed tests for memory modes, flops and the chain.
module sim_cfg_slice;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_in = '0, b_in = '0;
    logic       sel5 = 0, din_a = 0, we_a = 0, din_b = 0, we_b = 0;
    logic       ce = 0, sr = 0, gsr = 0, cfg_en = 0, cfg_si = 0;
    logic       cfg_so, comb_a, comb_f5, out_a, out_f5;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    cfg_slice u0 (.*);

    // Vectors: {table A, table B, a_in, b_in, sel5}.
    localparam logic [40:0] VEC [8] = '{
        {16'hA5C3, 16'h0F0F, 4'd0,  4'd0,  1'b0},
        {16'hA5C3, 16'h0F0F, 4'd1,  4'd4,  1'b1},
        {16'h8000, 16'h0001, 4'd15, 4'd0,  1'b0},
        {16'h8000, 16'h0001, 4'd15, 4'd0,  1'b1},
        {16'h6996, 16'hFFFE, 4'd7,  4'd0,  1'b1},
        {16'h6996, 16'hFFFE, 4'd3,  4'd9,  1'b1},
        {16'h1234, 16'hFEDC, 4'd2,  4'd5,  1'b0},
        {16'hFFFF, 16'h0000, 4'd9,  4'd9,  1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [39:0] cw(input logic [15:0] ta, input logic [15:0] tb,
                                       input logic [1:0] ma, input logic [1:0] mb,
                                       input logic oa, input logic of_, input logic sa, input logic sf);
        return {ta, tb, ma, mb, oa, of_, sa, sf};
    endfunction

    // Scan a 40-bit word in, MSB first; returns at the negedge where cfg_en drops.
    task automatic load(input logic [39:0] w);
        for (int i = 39; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_si = w[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_si = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] ta, tb, model;
        logic [39:0] w1, w2;
        int          bad;
        logic        old;

        // R1: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 comb_a", comb_a, 1'b0);
        chk("R1 out_f5", out_f5, 1'b0);
        chk("R1 cfg_so", cfg_so, 1'b0);

        // R3/R4: vector table in logic mode.
        foreach (VEC[k]) begin
            load(cw(VEC[k][40:25], VEC[k][24:9], 2'd0, 2'd0, 0, 0, 0, 0));
            a_in = VEC[k][8:5]; b_in = VEC[k][4:1]; sel5 = VEC[k][0];
            #1;
            chk("R3 table A", comb_a, VEC[k][25 + a_in]);
            chk("R4 f5", comb_f5, sel5 ? VEC[k][9 + b_in] : VEC[k][25 + a_in]);
            chk("R10 comb route", out_a, comb_a);
        end

        // R3/R4: random tables and inputs.
        for (int r = 0; r < 10; r++) begin
            ta = 16'($urandom); tb = 16'($urandom);
            load(cw(ta, tb, 2'd0, 2'd0, 0, 0, 0, 0));
            for (int p = 0; p < 4; p++) begin
                a_in = 4'($urandom); b_in = 4'($urandom); sel5 = 1'($urandom);
                #1;
                chk("R3 random", comb_a, ta[a_in]);
                chk("R4 random", comb_f5, sel5 ? tb[b_in] : ta[a_in]);
            end
        end

        // R2: serial out after a load and pass-through during the next load.
        w1 = 40'hC3_5A96_0F1E; w2 = 40'h12_3456_789A;
        load(w1);
        chk("R2 tail", cfg_so, w1[39]);
        bad = 0;
        for (int i = 39; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1; cfg_si = w2[i];
            #1;
            if (cfg_so !== w1[i]) bad++;
        end
        @(negedge clk); cfg_en = 1'b0;
        chk("R2 pass-through", bad == 0, 1'b1);

        // R7/R12: logic and alternate-logic code ignore writes.
        ta = 16'h5AF0; tb = 16'h3C69;
        load(cw(ta, tb, 2'd3, 2'd0, 0, 0, 0, 0));
        for (int c = 0; c < 10; c++) begin
            a_in = 4'($urandom); b_in = 4'($urandom); sel5 = 1'($urandom);
            we_a = 1; we_b = 1; din_a = 1'($urandom); din_b = 1'($urandom);
            @(negedge clk);
            #1;
            chk("R12 alt code as logic", comb_a, ta[a_in]);
            chk("R7 logic ignores write", comb_f5, sel5 ? tb[b_in] : ta[a_in]);
        end
        we_a = 0; we_b = 0;

        // R5: shift mode against a shadow register.
        model = 16'h8001;
        load(cw(model, 16'h0, 2'd1, 2'd0, 0, 0, 0, 0));
        sel5 = 0;
        for (int c = 0; c < 40; c++) begin
            a_in = (c < 20) ? 4'd15 : 4'($urandom);
            din_a = 1'($urandom); we_a = (c % 5 != 4);
            #1;
            chk("R5 shift tap", comb_a, model[a_in]);
            @(negedge clk);
            if (we_a) model = {model[14:0], din_a};
        end
        we_a = 0;

        // R6: RAM mode against a shadow memory.
        model = 16'h1234;
        load(cw(model, 16'h0, 2'd2, 2'd0, 0, 0, 0, 0));
        for (int c = 0; c < 40; c++) begin
            a_in = 4'($urandom); din_a = 1'($urandom); we_a = 1'($urandom);
            #1;
            chk("R6 ram read", comb_a, model[a_in]);
            @(negedge clk);
            if (we_a) model[a_in] = din_a;
            #1;
            chk("R6 ram after write", comb_a, model[a_in]);
        end
        we_a = 0;

        // Same cycle: RAM write and flop capture; flop takes the old value.
        load(cw(16'h0, 16'h0, 2'd2, 2'd0, 1, 0, 0, 0));
        a_in = 4'd5; din_a = 1; we_a = 1; ce = 1;
        #1;
        old = comb_a;
        chk("R6 pre-write", old, 1'b0);
        @(negedge clk);
        we_a = 0;
        #1;
        chk("R6 written", comb_a, 1'b1);
        chk("R8 captured old", out_a, 1'b0);
        @(negedge clk);
        #1;
        chk("R8 captured new", out_a, 1'b1);
        ce = 0;

        // R8/R9/R10/R11: flops in logic mode.
        ta = 16'hA5C3; tb = 16'h0F0F;
        load(cw(ta, tb, 2'd0, 2'd0, 1, 1, 1, 0));
        #1;
        chk("R11 flop cleared by load", out_a, 1'b0);
        a_in = 4'd1; b_in = 4'd0; sel5 = 1; ce = 1;
        @(negedge clk); #1;
        chk("R8 capture a", out_a, 1'b1);
        chk("R8 capture f5", out_f5, 1'b1);
        ce = 0; a_in = 4'd2; sel5 = 0;
        @(negedge clk); #1;
        chk("R8 hold a", out_a, 1'b1);
        chk("R8 comb moved", comb_a, 1'b0);
        ce = 1; sr = 1; sel5 = 1;
        @(negedge clk); #1;
        chk("R9 sr a", out_a, 1'b1);
        chk("R9 sr f5", out_f5, 1'b0);
        sr = 0;
        @(negedge clk); #1;
        chk("R8 recapture a", out_a, 1'b0);
        chk("R8 recapture f5", out_f5, 1'b1);
        ce = 0; gsr = 1;
        @(negedge clk); #1;
        chk("R9 gsr a", out_a, 1'b1);
        chk("R9 gsr f5", out_f5, 1'b0);
        gsr = 0; ce = 1; a_in = 4'd1;
        load(cw(ta, tb, 2'd0, 2'd0, 1, 1, 1, 0));
        #1;
        chk("R11 held during load", out_a, 1'b0);
        ce = 0;
        load(cw(ta, tb, 2'd0, 2'd0, 0, 1, 1, 0));
        #1;
        chk("R10 comb on out_a", out_a, comb_a);

        // R11: RAM-mode writes during a load do not alter the loaded table.
        we_a = 1; din_a = 1; a_in = 4'd0;
        load(cw(16'h0, 16'h0, 2'd2, 2'd0, 0, 0, 0, 0));
        we_a = 0;
        #1;
        chk("R11 write ignored in load", comb_a, 1'b0);

        // R1: reset after activity.
        rst_n = 0;
        @(negedge clk);
        rst_n = 1; a_in = 4'd15;
        #1;
        chk("R1 reset table", comb_a, 1'b0);
        chk("R1 reset so", cfg_so, 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule